// File: doc/BRIEF.md
# Gather Load Page Translation Coalescer

This block sits between a vector gather-load unit and a translation port. When a start pulse arrives it captures a scalar base address, one index per vector element and an active-element mask. It forms each element's effective address and virtual page number. It then runs leader-election rounds to cut down the number of page translations it sends. In each round the lowest-numbered element that still needs a translation becomes the leader. Its page is sent to the translation port. Every pending element on that same virtual page takes the returned physical page number and stops waiting.

The number of such rounds has a fixed upper limit. Any element still waiting after the last round is translated on its own, in ascending element order. When no element is left waiting, the block raises a one-cycle done pulse. The per-element page numbers, their valid flags and a count of the translations issued then stay steady until the next start. The translation port carries one request at a time. The request has a valid/ready handshake, and the answer comes back as a single-cycle response.

Top module: `gather_xlate_coalescer`

## Requirements
- R1: The virtual page number of element i is (base_addr + index i) modulo 2^ADDR_W, shifted right by PAGE_SHIFT (12, so 4 KiB pages). Index i occupies bits [i*ADDR_W +: ADDR_W] of index_flat.
- R2: In every round, the request carries the virtual page of the lowest-numbered element still pending. For the first round this is the lowest active element.
- R3: In a coalescing round, the response physical page number is written to every pending element whose virtual page equals the leader's page. Each of those elements gets its ppn_valid bit set, bit i for element i, with its page in ppn_flat[i*PPN_W +: PPN_W]. None of them sends a request again.
- R4: At most ROUNDS (4) coalescing rounds run. After that, each element still pending sends exactly one request of its own, in ascending element order, and receives only its own response.
- R5: Elements whose active_mask bit is 0 send no request and end with ppn_valid 0 and a page field of 0.
- R6: Once no element is pending, no further request is sent and done follows, even if fewer than ROUNDS rounds have run. An all-zero mask gives done with zero requests.
- R7: At most one request is outstanding. tlb_req_valid stays low from acceptance until the response. While tlb_req_ready is low, a raised request holds its valid and its page.
- R8: xlate_count is cleared at start and rises by one for each accepted request, so at done it equals the number of requests issued.
- R9: A start pulse while busy is high is ignored, and the run in progress finishes with its captured inputs.
- R10: done is high for exactly one cycle. From done until the next start, ppn_flat, ppn_valid and xlate_count do not change.
- R11: After reset, busy, done, tlb_req_valid, ppn_valid and xlate_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| base_addr | input | ADDR_W | Scalar base address |
| index_flat | input | NUM_ELEMS*ADDR_W | Per-element index values |
| active_mask | input | NUM_ELEMS | Elements taking part in the load |
| tlb_req_valid | output | 1 | Translation request present |
| tlb_req_ready | input | 1 | Translation port accepts the request |
| tlb_req_vpn | output | ADDR_W-PAGE_SHIFT | Virtual page number to translate |
| tlb_rsp_valid | input | 1 | Translation result present (one cycle) |
| tlb_rsp_ppn | input | PPN_W | Translated physical page number |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| ppn_flat | output | NUM_ELEMS*PPN_W | Per-element physical page numbers |
| ppn_valid | output | NUM_ELEMS | Per-element page-number valid |
| xlate_count | output | $clog2(NUM_ELEMS+1) | Requests accepted in this run |

## Verification
A start pulse sampled at a clock edge captures the inputs. A request becomes visible in the next cycle and is accepted at the first edge where ready is high. The bench's translation model answers in the cycle after acceptance, and the matched elements' results are registered at that response edge. Done rises one cycle after the last pending bit clears. The bench therefore polls done on falling edges and reads every result, together with the logged request order, at the falling edge where done is first seen. It samples again a few cycles later to confirm the values have held.

// File: rtl/gxc_pkg.sv
package gxc_pkg;
   typedef enum logic [1:0] {
      GX_IDLE  = 2'd0,
      GX_ISSUE = 2'd1,
      GX_WAIT  = 2'd2,
      GX_FIN   = 2'd3
   } gx_state_t;
endpackage

// File: rtl/gxc_ea_gen.sv
module gxc_ea_gen #(
   parameter int NUM_ELEMS  = 8,
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   localparam int VPN_W     = ADDR_W - PAGE_SHIFT
) (
   input  logic [ADDR_W-1:0]           base_addr,
   input  logic [NUM_ELEMS*ADDR_W-1:0] index_flat,
   output logic [NUM_ELEMS*VPN_W-1:0]  vpn_flat
);
   for (genvar g = 0; g < NUM_ELEMS; g++) begin : g_elem
      assign vpn_flat[g*VPN_W +: VPN_W] =
         VPN_W'((base_addr + index_flat[g*ADDR_W +: ADDR_W]) >> PAGE_SHIFT);
   end
endmodule

// File: rtl/gxc_ffs.sv
module gxc_ffs #(
   parameter int NUM_ELEMS = 8,
   localparam int IDX_W    = (NUM_ELEMS > 1) ? $clog2(NUM_ELEMS) : 1
) (
   input  logic [NUM_ELEMS-1:0] vec,
   output logic                 any,
   output logic [IDX_W-1:0]     idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = NUM_ELEMS - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/gxc_page_match.sv
module gxc_page_match #(
   parameter int NUM_ELEMS = 8,
   parameter int VPN_W     = 20
) (
   input  logic [NUM_ELEMS*VPN_W-1:0] vpn_flat,
   input  logic [VPN_W-1:0]           key,
   input  logic [NUM_ELEMS-1:0]       en,
   output logic [NUM_ELEMS-1:0]       hit
);
   for (genvar g = 0; g < NUM_ELEMS; g++) begin : g_cmp
      assign hit[g] = en[g] && (vpn_flat[g*VPN_W +: VPN_W] == key);
   end
endmodule

// File: rtl/gather_xlate_coalescer.sv
module gather_xlate_coalescer
   import gxc_pkg::*;
#(
   parameter int NUM_ELEMS  = 8,
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int PPN_W      = 20,
   parameter int ROUNDS     = 4,
   localparam int VPN_W     = ADDR_W - PAGE_SHIFT,
   localparam int IDX_W     = (NUM_ELEMS > 1) ? $clog2(NUM_ELEMS) : 1,
   localparam int CNT_W     = $clog2(NUM_ELEMS + 1),
   localparam int RND_W     = $clog2(ROUNDS + 2)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [ADDR_W-1:0]            base_addr,
   input  logic [NUM_ELEMS*ADDR_W-1:0]  index_flat,
   input  logic [NUM_ELEMS-1:0]         active_mask,
   output logic                         tlb_req_valid,
   input  logic                         tlb_req_ready,
   output logic [VPN_W-1:0]             tlb_req_vpn,
   input  logic                         tlb_rsp_valid,
   input  logic [PPN_W-1:0]             tlb_rsp_ppn,
   output logic                         busy,
   output logic                         done,
   output logic [NUM_ELEMS*PPN_W-1:0]   ppn_flat,
   output logic [NUM_ELEMS-1:0]         ppn_valid,
   output logic [CNT_W-1:0]             xlate_count
);
   if (NUM_ELEMS < 1) begin : g_bad_elems
      $error("NUM_ELEMS must be at least 1");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("PAGE_SHIFT must lie inside the address");
   end
   if (ROUNDS < 0) begin : g_bad_rounds
      $error("ROUNDS must not be negative");
   end

   gx_state_t              st_q;
   logic [NUM_ELEMS*VPN_W-1:0] vpn_in, vpn_q;
   logic [NUM_ELEMS-1:0]   pend_q, vld_q, hit, wr_mask;
   logic [PPN_W-1:0]       ppn_q [NUM_ELEMS];
   logic [IDX_W-1:0]       lead_idx, lead_q;
   logic                   pend_any, coal_q;
   logic [RND_W-1:0]       round_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [VPN_W-1:0]       lead_vpn;

   gxc_ea_gen #(.NUM_ELEMS(NUM_ELEMS), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_ea (
      .base_addr (base_addr),
      .index_flat(index_flat),
      .vpn_flat  (vpn_in)
   );

   gxc_ffs #(.NUM_ELEMS(NUM_ELEMS)) u_ffs (
      .vec(pend_q),
      .any(pend_any),
      .idx(lead_idx)
   );

   assign lead_vpn = vpn_q[lead_q*VPN_W +: VPN_W];

   gxc_page_match #(.NUM_ELEMS(NUM_ELEMS), .VPN_W(VPN_W)) u_match (
      .vpn_flat(vpn_q),
      .key     (lead_vpn),
      .en      (pend_q),
      .hit     (hit)
   );

   // coalescing rounds share one answer; the tail phase writes the leader only
   assign wr_mask = coal_q ? hit : (NUM_ELEMS'(1) << lead_q);

   assign tlb_req_valid = (st_q == GX_ISSUE) && pend_any;
   assign tlb_req_vpn   = vpn_q[lead_idx*VPN_W +: VPN_W];
   assign busy          = (st_q != GX_IDLE);
   assign done          = (st_q == GX_FIN);
   assign ppn_valid     = vld_q;
   assign xlate_count   = cnt_q;

   for (genvar g = 0; g < NUM_ELEMS; g++) begin : g_out
      assign ppn_flat[g*PPN_W +: PPN_W] = ppn_q[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= GX_IDLE;
         vpn_q   <= '0;
         pend_q  <= '0;
         vld_q   <= '0;
         lead_q  <= '0;
         coal_q  <= 1'b0;
         round_q <= '0;
         cnt_q   <= '0;
         for (int i = 0; i < NUM_ELEMS; i++) ppn_q[i] <= '0;
      end else begin
         case (st_q)
            GX_IDLE: begin
               if (start) begin
                  st_q    <= GX_ISSUE;
                  vpn_q   <= vpn_in;
                  pend_q  <= active_mask;
                  vld_q   <= '0;
                  coal_q  <= (ROUNDS > 0);
                  round_q <= '0;
                  cnt_q   <= '0;
                  for (int i = 0; i < NUM_ELEMS; i++) ppn_q[i] <= '0;
               end
            end
            GX_ISSUE: begin
               if (!pend_any) begin
                  st_q <= GX_FIN;
               end else if (tlb_req_ready) begin
                  st_q   <= GX_WAIT;
                  lead_q <= lead_idx;
                  cnt_q  <= cnt_q + CNT_W'(1);
               end
            end
            GX_WAIT: begin
               if (tlb_rsp_valid) begin
                  st_q   <= GX_ISSUE;
                  pend_q <= pend_q & ~wr_mask;
                  vld_q  <= vld_q | wr_mask;
                  for (int i = 0; i < NUM_ELEMS; i++) begin
                     if (wr_mask[i]) ppn_q[i] <= tlb_rsp_ppn;
                  end
                  if (coal_q) begin
                     round_q <= round_q + RND_W'(1);
                     if (round_q == RND_W'(ROUNDS - 1)) coal_q <= 1'b0;
                  end
               end
            end
            default: st_q <= GX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/gxc_checker.sv
module gxc_checker #(
   parameter int NUM_ELEMS = 8,
   parameter int VPN_W     = 20,
   parameter int PPN_W     = 20,
   parameter int CNT_W     = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic [NUM_ELEMS-1:0]       active_mask,
   input logic                       tlb_req_valid,
   input logic                       tlb_req_ready,
   input logic [VPN_W-1:0]           tlb_req_vpn,
   input logic                       tlb_rsp_valid,
   input logic                       busy,
   input logic                       done,
   input logic [NUM_ELEMS*PPN_W-1:0] ppn_flat,
   input logic [NUM_ELEMS-1:0]       ppn_valid,
   input logic [CNT_W-1:0]           xlate_count
);
   logic                 outst_q;
   logic [NUM_ELEMS-1:0] cap_mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst_q    <= 1'b0;
         cap_mask_q <= '0;
      end else begin
         if (tlb_req_valid && tlb_req_ready) outst_q <= 1'b1;
         else if (tlb_rsp_valid)             outst_q <= 1'b0;
         if (!busy && start) cap_mask_q <= active_mask;
      end
   end

   // R7
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outst_q |-> !tlb_req_valid);

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_req_valid && !tlb_req_ready) |=> (tlb_req_valid && $stable(tlb_req_vpn)));

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tlb_req_valid && tlb_req_ready) |=> (xlate_count == $past(xlate_count) + CNT_W'(1)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || (!busy && !start)) |=>
         ($stable(ppn_flat) && $stable(ppn_valid) && $stable(xlate_count)));

   // R6
   quiet_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tlb_req_valid);

   // R5
   inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((ppn_valid & ~cap_mask_q) == '0));
endmodule

bind gather_xlate_coalescer gxc_checker #(
   .NUM_ELEMS(NUM_ELEMS), .VPN_W(VPN_W), .PPN_W(PPN_W), .CNT_W(CNT_W)
) u_gxc_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .active_mask(active_mask),
   .tlb_req_valid(tlb_req_valid), .tlb_req_ready(tlb_req_ready),
   .tlb_req_vpn(tlb_req_vpn), .tlb_rsp_valid(tlb_rsp_valid), .busy(busy),
   .done(done), .ppn_flat(ppn_flat), .ppn_valid(ppn_valid),
   .xlate_count(xlate_count)
);

// File: tb/gather_xlate_coalescer_test.sv
module gather_xlate_coalescer_test;
   localparam int NE = 8, AW = 32, PS = 12, PW = 20, NR = 4;
   localparam int VW = AW - PS, CW = $clog2(NE + 1);
   localparam int NV = 7;
   localparam logic [PW-1:0] XMAP = 20'h5A3C1;

   // table: base, packed page codes (element i in bits [i*8 +: 8]), mask, expected request count
   localparam logic [31:0] V_BASE [NV] = '{32'h1000_0000, 32'h0, 32'h0020_0000, 32'h0,
                                           32'hFFFF_F800, 32'h0003_0000, 32'h0};
   localparam logic [63:0] V_PAGE [NV] = '{64'h0, 64'h0706050403020100, 64'h0404030102000100,
                                           64'h0706050403020100, 64'h0100010001000100,
                                           64'h0706050403020100, 64'h0706050403020100};
   localparam logic [7:0]  V_MASK [NV] = '{8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'hFF, 8'h00, 8'h81};
   localparam int          V_CNT  [NV] = '{1, 8, 6, 4, 2, 0, 2};

   logic clk = 0, rst_n = 0, start = 0;
   logic [AW-1:0] base_addr = '0;
   logic [NE*AW-1:0] index_flat = '0;
   logic [NE-1:0] active_mask = '0;
   logic tlb_req_valid, tlb_req_ready = 1'b1, tlb_rsp_valid = 1'b0;
   logic [VW-1:0] tlb_req_vpn;
   logic [PW-1:0] tlb_rsp_ppn = '0;
   logic busy, done;
   logic [NE*PW-1:0] ppn_flat;
   logic [NE-1:0] ppn_valid;
   logic [CW-1:0] xlate_count;

   always #2 clk = ~clk;

   gather_xlate_coalescer #(.NUM_ELEMS(NE), .ADDR_W(AW), .PAGE_SHIFT(PS), .PPN_W(PW), .ROUNDS(NR)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .index_flat(index_flat),
      .active_mask(active_mask), .tlb_req_valid(tlb_req_valid), .tlb_req_ready(tlb_req_ready),
      .tlb_req_vpn(tlb_req_vpn), .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_ppn(tlb_rsp_ppn),
      .busy(busy), .done(done), .ppn_flat(ppn_flat), .ppn_valid(ppn_valid),
      .xlate_count(xlate_count));

   int n_chk = 0, n_bad = 0;
   logic [VW-1:0] req_log [64];
   int req_n = 0, overlap = 0;
   bit outst = 0, rsp_due = 0, stall = 0;
   logic [VW-1:0] last_vpn = '0;
   int tick = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // translation port model: log accepted requests, answer one cycle later
   always @(posedge clk) begin
      if (rst_n) begin
         if (tlb_rsp_valid) outst = 0;
         if (tlb_req_valid && outst) overlap++;
         if (tlb_req_valid && tlb_req_ready) begin
            if (req_n < 64) req_log[req_n] = tlb_req_vpn;
            req_n++;
            last_vpn = tlb_req_vpn;
            outst = 1;
            rsp_due = 1;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         tick++;
         tlb_req_ready = stall ? ((tick % 3) == 2) : 1'b1;
         if (rsp_due) begin
            tlb_rsp_valid = 1'b1;
            tlb_rsp_ppn   = last_vpn ^ XMAP;
            rsp_due = 0;
         end else begin
            tlb_rsp_valid = 1'b0;
         end
      end
   end

   function automatic logic [VW-1:0] vpn_of(input logic [31:0] b, input logic [63:0] pg, input int i);
      logic [31:0] ea;
      ea = b + {pg[i*8 +: 8], 12'h000} + 32'(i * 16);
      return ea[31:12];
   endfunction

   task automatic drive(input logic [31:0] b, input logic [63:0] pg, input logic [7:0] m);
      base_addr = b;
      active_mask = m;
      for (int i = 0; i < NE; i++) index_flat[i*AW +: AW] = {pg[i*8 +: 8], 12'h000} + 32'(i * 16);
   endtask

   task automatic wait_done(output bit seen);
      seen = 0;
      for (int c = 0; c < 400 && !seen; c++) begin
         @(negedge clk);
         if (done) seen = 1;
      end
   endtask

   task automatic verify(input logic [31:0] b, input logic [63:0] pg, input logic [7:0] m,
                         input int exp_cnt, input string tag);
      logic [VW-1:0] seq [16];
      logic [NE-1:0] pend;
      logic [NE*PW-1:0] exp_ppn;
      int sn, rnd;
      bit seq_ok;
      pend = m; sn = 0; rnd = 0; exp_ppn = '0;
      for (int i = 0; i < NE; i++)
         if (m[i]) exp_ppn[i*PW +: PW] = vpn_of(b, pg, i) ^ XMAP;
      while (pend != 0 && rnd < NR) begin
         logic [VW-1:0] key;
         int l;
         l = 0;
         for (int i = NE - 1; i >= 0; i--) if (pend[i]) l = i;
         key = vpn_of(b, pg, l);
         seq[sn] = key; sn++;
         for (int i = 0; i < NE; i++) if (pend[i] && vpn_of(b, pg, i) == key) pend[i] = 1'b0;
         rnd++;
      end
      for (int i = 0; i < NE; i++) if (pend[i]) begin seq[sn] = vpn_of(b, pg, i); sn++; end
      // R8 R4 R6: count of requests
      check(xlate_count == CW'(exp_cnt) && sn == exp_cnt, "R8", {tag, " count"}, 256'(xlate_count), 256'(exp_cnt));
      // R2 R4 R1: request order and pages
      seq_ok = (req_n == sn);
      for (int k = 0; k < sn && k < 16; k++) if (seq_ok && req_log[k] != seq[k]) seq_ok = 0;
      check(seq_ok, "R2/R4", {tag, " request sequence"}, 256'(req_n), 256'(sn));
      // R3 R5: per-element results
      check(ppn_valid == m, "R5", {tag, " ppn_valid"}, 256'(ppn_valid), 256'(m));
      check(ppn_flat == exp_ppn, "R3", {tag, " ppn_flat"}, 256'(ppn_flat), 256'(exp_ppn));
   endtask

   task automatic run(input logic [31:0] b, input logic [63:0] pg, input logic [7:0] m,
                      input int exp_cnt, input string tag);
      bit seen;
      logic [NE*PW-1:0] snap_p;
      logic [NE-1:0] snap_v;
      @(negedge clk);
      drive(b, pg, m);
      req_n = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      check(seen, "R6", {tag, " done seen"}, 256'(seen), 256'(1));
      verify(b, pg, m, exp_cnt, tag);
      snap_p = ppn_flat; snap_v = ppn_valid;
      drive(32'hDEAD_0000, 64'h1111111111111111, 8'h3C);
      repeat (3) @(negedge clk);
      // R10: single-cycle pulse and held results
      check(!done && !busy, "R10", {tag, " done pulse"}, 256'(done), 256'(0));
      check(ppn_flat == snap_p && ppn_valid == snap_v && xlate_count == CW'(exp_cnt),
            "R10", {tag, " held"}, 256'(ppn_flat), 256'(snap_p));
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(!busy && !done && !tlb_req_valid && ppn_valid == '0 && xlate_count == '0,
            "R11", "reset state", 256'({busy, done, tlb_req_valid, ppn_valid}), 256'(0));
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++)
         run(V_BASE[v], V_PAGE[v], V_MASK[v], V_CNT[v], $sformatf("R1 vec%0d", v));

      // R7: back-pressure on the request port, same pages as vec2
      stall = 1;
      run(V_BASE[2], V_PAGE[2], V_MASK[2], V_CNT[2], "R7 stalled");
      stall = 0;
      check(overlap == 0, "R7", "requests while outstanding", 256'(overlap), 256'(0));

      // R9: second start during a run is ignored
      begin
         bit seen;
         @(negedge clk);
         drive(V_BASE[1], V_PAGE[1], V_MASK[1]);
         req_n = 0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         @(negedge clk);
         drive(32'h4000_0000, 64'h0, 8'h0F);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wait_done(seen);
         check(seen, "R9", "done after ignored start", 256'(seen), 256'(1));
         verify(V_BASE[1], V_PAGE[1], V_MASK[1], V_CNT[1], "R9 busy start");
         @(negedge clk);
         check(!busy, "R9", "no rerun", 256'(busy), 256'(0));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule